// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Capture

This block is one bank of general-purpose pads, up to 32 wide, controlled over a simple 32-bit register bus. Software drives the pads through an output data register and a direction register. Each of these has a write-one-to-set address and a write-one-to-clear address, so a single pin can be changed without a read-modify-write. Pad inputs pass through a two-flop synchronizer. The synchronized value can be read back, and it also feeds the interrupt logic.

Each pin has its own interrupt detector. A sense register selects edge or level detection. A polarity register and a both-edges register select which transitions or which level count. Detected events set bits in a sticky pending register, and software clears those bits by writing ones. An enable mask, changed only through separate set and clear addresses, decides which pending bits reach the single combined interrupt output. Pin muxing, clock gating and cascading into an interrupt controller are handled outside this block.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads zero except the polarity register at 0x18, which reads all ones (falling edge / low level). pad_out, pad_oe and irq_out are low.
- R2: A write to 0x00 loads the output data. Writing ones to 0x40 sets those output bits and writing ones to 0x44 clears them, and zero bits leave the output unchanged. pad_out follows the output data register, which reads back at 0x00.
- R3: A direction bit of 1 makes the pin an output, shown on pad_oe. A write to 0x08 loads the direction register, ones written to 0x48 set bits and ones written to 0x4C clear bits. The register reads back at 0x08.
- R4: A read of 0x04 returns the pad inputs after a two-flop synchronizer. Writes to 0x04 are ignored.
- R5: In edge mode (sense bit at 0x2C is 0) with the both-edges bit at 0x1C equal to 0, a polarity bit (0x18) of 0 captures a rising edge and a polarity bit of 1 captures a falling edge. A capture sets that pin's bit in the pending register at 0x20.
- R6: In edge mode with the both-edges bit equal to 1, either transition of the pin is captured, whatever the polarity bit holds.
- R7: In level mode (sense bit 1), the pending bit is set on every cycle that the pin is at its active level: high for polarity 0, low for polarity 1. The both-edges bit is ignored. A clear therefore does not last while that level persists.
- R8: Writing ones to 0x20 clears those pending bits and zeros have no effect. When a capture and a clear reach the same bit in the same cycle, the capture wins.
- R9: Ones written to 0x30 enable those pins and ones written to 0x34 disable them. irq_out is high when any pending bit is enabled. Capture does not depend on the enable.
- R10: The read data is registered and appears in the cycle after the read request. Reads of the alias addresses (0x30, 0x34, 0x40, 0x44, 0x48, 0x4C) and of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle after a read |
| pad_in | input | NUM_PINS | Asynchronous pad inputs |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The assertions assume single-cycle bus accesses, with at most one register touched per cycle, and a pad bus no wider than the data bus. The bench keeps to both: it raises bus_sel for exactly one cycle per access and uses the default width. Pad inputs change only away from the clock edge and are then held for several cycles. This lets the synchronizer settle, so the expected pending state can be computed from the old and new pad values alone. Random register writes, random pad toggles and random reads are mixed with directed checks of each trigger mode, the clear-versus-level race and the enable mask.

// File: rtl/gpio_bank_pkg.sv
// Package: register offsets shared by the GPIO bank and its bench.
// Assumes byte addresses on a 32-bit register bus.
package gpio_bank_pkg;
    localparam logic [7:0] OFF_DOUT     = 8'h00;
    localparam logic [7:0] OFF_DIN      = 8'h04;
    localparam logic [7:0] OFF_DIR      = 8'h08;
    localparam logic [7:0] OFF_POL      = 8'h18;
    localparam logic [7:0] OFF_BOTH     = 8'h1C;
    localparam logic [7:0] OFF_PEND     = 8'h20;
    localparam logic [7:0] OFF_SENSE    = 8'h2C;
    localparam logic [7:0] OFF_EN_SET   = 8'h30;
    localparam logic [7:0] OFF_EN_CLR   = 8'h34;
    localparam logic [7:0] OFF_DOUT_SET = 8'h40;
    localparam logic [7:0] OFF_DOUT_CLR = 8'h44;
    localparam logic [7:0] OFF_DIR_SET  = 8'h48;
    localparam logic [7:0] OFF_DIR_CLR  = 8'h4C;
endpackage

// File: rtl/gpio_pad_sync.sv
// Module: gpio_pad_sync
// Brings asynchronous pad inputs into the clock domain with two flops.
// It also keeps the synchronized value from one cycle earlier, for edge detection.
// Assumes each pad is held long enough to be seen by at least one sampling edge.
module gpio_pad_sync #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] sync_q,
    output logic [NUM_PINS-1:0] sync_prev
);
    logic [NUM_PINS-1:0] meta_q;

    // Two-stage synchronizer plus a one-cycle history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q    <= '0;
            sync_q    <= '0;
            sync_prev <= '0;
        end else begin
            meta_q    <= pad_in;
            sync_q    <= meta_q;
            sync_prev <= sync_q;
        end
    end
endmodule

// File: rtl/gpio_irq_detect.sv
// Module: gpio_irq_detect
// Per-pin trigger evaluation and the sticky pending register.
// Assumes clr_mask is nonzero only in a cycle that writes the pending register.
// When a capture and a clear meet on one bit, the capture wins.
module gpio_irq_detect #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] sync_q,
    input  logic [NUM_PINS-1:0] sync_prev,
    input  logic [NUM_PINS-1:0] sense_level,
    input  logic [NUM_PINS-1:0] trig_pol,
    input  logic [NUM_PINS-1:0] trig_both,
    input  logic [NUM_PINS-1:0] clr_mask,
    output logic [NUM_PINS-1:0] pend_q
);
    logic [NUM_PINS-1:0] hit;

    // One trigger decoder per pin: level, both edges, falling or rising.
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        assign hit[i] = sense_level[i] ? (sync_q[i] ^ trig_pol[i])
                      : trig_both[i]   ? (sync_q[i] ^ sync_prev[i])
                      : trig_pol[i]    ? (sync_prev[i] & ~sync_q[i])
                      :                  (sync_q[i] & ~sync_prev[i]);
    end

    // Pending bits: set by a trigger, cleared by write-one, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_mask) | hit;
    end

    // R5 R7 R8: every trigger is recorded in the next cycle, even under a clear.
    p_capture_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((pend_q & $past(hit)) == $past(hit)));

    // R8: pending bits are sticky while no clear is applied.
    p_pend_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: rtl/gpio_irq_bank.sv
// Module: gpio_irq_bank (top)
// One memory-mapped GPIO bank. It holds output data and direction registers with
// set/clear aliases, a synchronized input readback and per-pin interrupt capture.
// It drives one combined interrupt line.
// Assumes single-cycle bus accesses and NUM_PINS <= 32. Read data is registered.
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                irq_out
);
    localparam logic [NUM_PINS-1:0] ALL_ONES = '1;

    logic                wr_en, rd_en;
    logic [NUM_PINS-1:0] wd;
    logic [NUM_PINS-1:0] dout_q, dir_q, pol_q, both_q, sense_q, en_q;
    logic [NUM_PINS-1:0] sync_q, sync_prev, pend_q, clr_mask;
    logic [31:0]         rd_val;

    assign wr_en = bus_sel & bus_wr;
    assign rd_en = bus_sel & ~bus_wr;
    assign wd    = bus_wdata[NUM_PINS-1:0];

    // Decode of one write strobe per address.
    function automatic logic hit_wr(input logic [7:0] off);
        return wr_en && (bus_addr == ADDR_W'(off));
    endfunction

    gpio_pad_sync #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pad_in    (pad_in),
        .sync_q    (sync_q),
        .sync_prev (sync_prev)
    );

    assign clr_mask = hit_wr(OFF_PEND) ? wd : '0;

    gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_q      (sync_q),
        .sync_prev   (sync_prev),
        .sense_level (sense_q),
        .trig_pol    (pol_q),
        .trig_both   (both_q),
        .clr_mask    (clr_mask),
        .pend_q      (pend_q)
    );

    // Output data: direct load or bitwise set/clear aliases.
    always_ff @(posedge clk) begin
        if (!rst_n)                    dout_q <= '0;
        else if (hit_wr(OFF_DOUT))     dout_q <= wd;
        else if (hit_wr(OFF_DOUT_SET)) dout_q <= dout_q | wd;
        else if (hit_wr(OFF_DOUT_CLR)) dout_q <= dout_q & ~wd;
    end

    // Direction: direct load or bitwise set/clear aliases, 1 = output.
    always_ff @(posedge clk) begin
        if (!rst_n)                   dir_q <= '0;
        else if (hit_wr(OFF_DIR))     dir_q <= wd;
        else if (hit_wr(OFF_DIR_SET)) dir_q <= dir_q | wd;
        else if (hit_wr(OFF_DIR_CLR)) dir_q <= dir_q & ~wd;
    end

    // Trigger configuration; polarity resets to falling edge / low level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q   <= ALL_ONES;
            both_q  <= '0;
            sense_q <= '0;
        end else begin
            if (hit_wr(OFF_POL))   pol_q   <= wd;
            if (hit_wr(OFF_BOTH))  both_q  <= wd;
            if (hit_wr(OFF_SENSE)) sense_q <= wd;
        end
    end

    // Enable mask: changed only through its set and clear addresses.
    always_ff @(posedge clk) begin
        if (!rst_n)                  en_q <= '0;
        else if (hit_wr(OFF_EN_SET)) en_q <= en_q | wd;
        else if (hit_wr(OFF_EN_CLR)) en_q <= en_q & ~wd;
    end

    // Read multiplexer; aliases and unmapped addresses return zero.
    always_comb begin
        rd_val = '0;
        if      (bus_addr == ADDR_W'(OFF_DOUT))  rd_val = 32'(dout_q);
        else if (bus_addr == ADDR_W'(OFF_DIN))   rd_val = 32'(sync_q);
        else if (bus_addr == ADDR_W'(OFF_DIR))   rd_val = 32'(dir_q);
        else if (bus_addr == ADDR_W'(OFF_POL))   rd_val = 32'(pol_q);
        else if (bus_addr == ADDR_W'(OFF_BOTH))  rd_val = 32'(both_q);
        else if (bus_addr == ADDR_W'(OFF_PEND))  rd_val = 32'(pend_q);
        else if (bus_addr == ADDR_W'(OFF_SENSE)) rd_val = 32'(sense_q);
    end

    // Registered read data, updated only by a read request.
    always_ff @(posedge clk) begin
        if (!rst_n)     bus_rdata <= '0;
        else if (rd_en) bus_rdata <= rd_val;
    end

    assign pad_out = dout_q;
    assign pad_oe  = dir_q;
    assign irq_out = |(pend_q & en_q);

    // R2: the set alias raises exactly the written bits of the output.
    p_out_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == ADDR_W'(OFF_DOUT_SET))
        |=> (pad_out == ($past(pad_out) | $past(wd))));

    // R3: the direction clear alias turns the written pins into inputs.
    p_dir_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == ADDR_W'(OFF_DIR_CLR))
        |=> ((pad_oe & $past(wd)) == '0));

    // R9: disabling every pin silences the interrupt in the next cycle.
    p_en_clr_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == ADDR_W'(OFF_EN_CLR) && wd == ALL_ONES)
        |=> !irq_out);

    // R10: a read of an alias address returns zero.
    p_alias_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (bus_addr == ADDR_W'(OFF_DOUT_SET) || bus_addr == ADDR_W'(OFF_EN_SET)))
        |=> (bus_rdata == 32'd0));
endmodule

// File: tb/gpio_irq_bank_bench.sv
// Bench for gpio_irq_bank: directed corner cases plus seeded random traffic,
// checked against a register model written from the requirements.
module gpio_irq_bank_bench;
    import gpio_bank_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic        irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Model state
    logic [31:0] m_dout = '0, m_dir = '0, m_pol = '1, m_both = '0;
    logic [31:0] m_sense = '0, m_en = '0, m_pend = '0, m_pad = '0;

    always #10 clk = ~clk;

    gpio_irq_bank u_gpio_irq_bank (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
    );

    function automatic logic [31:0] level_active(input logic [31:0] p);
        return m_sense & (p ^ m_pol);
    endfunction

    function automatic logic [31:0] edge_hits(input logic [31:0] o, input logic [31:0] n);
        return ~m_sense & ((m_both & (o ^ n))
                         | (~m_both & ~m_pol & ~o & n)
                         | (~m_both &  m_pol & o & ~n));
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            OFF_DOUT:  return m_dout;
            OFF_DIN:   return m_pad;
            OFF_DIR:   return m_dir;
            OFF_POL:   return m_pol;
            OFF_BOTH:  return m_both;
            OFF_PEND:  return m_pend;
            OFF_SENSE: return m_sense;
            default:   return 32'd0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_pins(input string req);
        chk({req, " pad_out"}, pad_out, m_dout);
        chk({req, " pad_oe"}, pad_oe, m_dir);
        chk({req, " irq_out"}, {31'd0, irq_out}, {31'd0, |(m_pend & m_en)});
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_sel = 0; bus_wr = 0;
        @(negedge clk);
        case (a)
            OFF_DOUT:     m_dout  = d;
            OFF_DIR:      m_dir   = d;
            OFF_POL:      m_pol   = d;
            OFF_BOTH:     m_both  = d;
            OFF_PEND:     m_pend  = m_pend & ~d;
            OFF_SENSE:    m_sense = d;
            OFF_EN_SET:   m_en    = m_en | d;
            OFF_EN_CLR:   m_en    = m_en & ~d;
            OFF_DOUT_SET: m_dout  = m_dout | d;
            OFF_DOUT_CLR: m_dout  = m_dout & ~d;
            OFF_DIR_SET:  m_dir   = m_dir | d;
            OFF_DIR_CLR:  m_dir   = m_dir & ~d;
            default: ;
        endcase
        m_pend = m_pend | level_active(m_pad);
    endtask

    task automatic bus_read_chk(input string req, input logic [7:0] a);
        @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk); bus_sel = 0;
        chk(req, bus_rdata, exp_read(a));
    endtask

    task automatic set_pads(input logic [31:0] v);
        @(negedge clk); pad_in = v;
        repeat (4) @(negedge clk);
        m_pend = m_pend | edge_hits(m_pad, v) | level_active(v);
        m_pad  = v;
    endtask

    function automatic logic [7:0] pick_addr(input int k);
        case (k)
            0: return OFF_DOUT;   1: return OFF_DIN;      2: return OFF_DIR;
            3: return OFF_POL;    4: return OFF_BOTH;     5: return OFF_PEND;
            6: return OFF_SENSE;  7: return OFF_EN_SET;   8: return OFF_EN_CLR;
            9: return OFF_DOUT_SET; 10: return OFF_DOUT_CLR; 11: return OFF_DIR_SET;
            12: return OFF_DIR_CLR; 13: return 8'h10;     14: return 8'h24;
            default: return OFF_PEND;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk_pins("R1");
        bus_read_chk("R1 dout", OFF_DOUT);
        bus_read_chk("R1 dir", OFF_DIR);
        bus_read_chk("R1 pol", OFF_POL);
        bus_read_chk("R1 both", OFF_BOTH);
        bus_read_chk("R1 pend", OFF_PEND);
        bus_read_chk("R1 sense", OFF_SENSE);

        // R2 output data and aliases
        bus_write(OFF_DOUT, 32'h0000_00F0);
        bus_write(OFF_DOUT_SET, 32'h0000_0003);
        bus_write(OFF_DOUT_CLR, 32'h0000_0010);
        chk_pins("R2");
        bus_read_chk("R2 dout", OFF_DOUT);

        // R3 direction and aliases
        bus_write(OFF_DIR, 32'h8000_0001);
        bus_write(OFF_DIR_SET, 32'h0000_0100);
        bus_write(OFF_DIR_CLR, 32'h8000_0000);
        chk_pins("R3");
        bus_read_chk("R3 dir", OFF_DIR);

        // R4 synchronized input; writes ignored
        set_pads(32'hA5A5_0000);
        bus_write(OFF_DIN, 32'hFFFF_FFFF);
        bus_read_chk("R4 din", OFF_DIN);

        // R5 default falling-edge capture, then rising with polarity 0
        bus_write(OFF_PEND, 32'hFFFF_FFFF);
        bus_read_chk("R8 cleared", OFF_PEND);
        set_pads(32'h2525_0000);
        bus_read_chk("R5 falling", OFF_PEND);
        bus_write(OFF_PEND, 32'hFFFF_FFFF);
        bus_write(OFF_POL, 32'h0000_0000);
        set_pads(32'h2525_000F);
        bus_read_chk("R5 rising", OFF_PEND);

        // R6 both edges
        bus_write(OFF_PEND, 32'hFFFF_FFFF);
        bus_write(OFF_BOTH, 32'h0000_00FF);
        set_pads(32'h2525_00F0);
        bus_read_chk("R6 both", OFF_PEND);

        // R9 enable mask
        bus_write(OFF_EN_SET, 32'h0000_0010);
        chk_pins("R9 enabled");
        bus_write(OFF_EN_CLR, 32'h0000_0010);
        chk_pins("R9 disabled");
        bus_write(OFF_EN_SET, 32'h0000_0001);
        chk_pins("R9 other pin");

        // R7/R8 level mode: clear cannot stick while the level persists
        bus_write(OFF_PEND, 32'hFFFF_FFFF);
        bus_write(OFF_SENSE, 32'h0000_0030);
        bus_write(OFF_PEND, 32'h0000_0030);
        bus_read_chk("R7 level holds", OFF_PEND);
        set_pads(32'h2525_0000);
        bus_write(OFF_PEND, 32'h0000_0030);
        bus_read_chk("R7 level gone", OFF_PEND);
        bus_write(OFF_SENSE, 32'h0000_0000);

        // R10 alias and unmapped reads
        bus_read_chk("R10 enset", OFF_EN_SET);
        bus_read_chk("R10 dirclr", OFF_DIR_CLR);
        bus_read_chk("R10 unmapped", 8'h24);

        // Random traffic
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom % 4);
            if (op == 0) set_pads(m_pad ^ ($urandom & $urandom));
            else bus_write(pick_addr(int'($urandom % 16)), $urandom);
            chk_pins("R9 random");
            bus_read_chk("R10 random read", pick_addr(int'($urandom % 16)));
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule